// File: doc/BRIEF.md
# Host-to-Device Virtual Wire Group

This block keeps the current value of four virtual wires that a host sets remotely. An upstream parser delivers each decoded update as a message of three parts: a valid strobe, an 8-bit group index and an 8-bit payload. The block takes a message only when the index equals the index programmed into it. Within the payload, a mask nibble chooses which wires change, and a value nibble gives their new states.

Each wire carries its own interrupt detector. The detector is programmed for one of these modes: low level, high level, rising edge, falling edge, either edge, or off. Edge requests come from comparing each new wire value with the value it held before the update. A software-chosen reset pattern is loaded into the four wires when one selected reset line, out of four, rises. A small register port sets the index, the reset line choice, the reset pattern and the four detection modes, and reads back the wire states.

Top module: `vw_host_group`

## Requirements
- R1: When `rst_ni` is low, all four wires clear to 0, the configuration word clears to 0, the mode word is set to 0x04040404 (every wire off) and `irq_o` is 0.
- R2: The configuration word is at address 0. Host index is in bits 7:0, reset line select in bits 9:8 and the reset pattern in bits 15:12, with bit 12+i for wire i. All other bits read as 0.
- R3: The mode word is at address 1, with the 4-bit mode of wire i in bits 8i+3:8i. The state word is at address 2, with wire i at bit 8i and every other bit 0.
- R4: A message with `msg_valid_i` high and a matching index updates wire i to `msg_data_i[i]` only when its mask bit `msg_data_i[4+i]` is 1. The update is visible in the cycle after the message.
- R5: A message is ignored if its index differs from the programmed index, or if the programmed index is below 2.
- R6: A rising edge on `rst_lines_i[s]` loads the reset pattern into the four wires, where s is the select field. The line mapping is 0 = link reset, 1 = system reset, 2 = super-I/O reset, 3 = platform reset. Edges on unselected lines have no effect. A reload takes priority over a message in the same cycle.
- R7: Mode 0 drives `irq_o[i]` high for as long as wire i is 0. Mode 1 drives it high for as long as wire i is 1.
- R8: Modes 13, 14 and 15 (rising, falling, either) produce a single-cycle pulse on `irq_o[i]` in the cycle after a message changes wire i in the matching direction.
- R9: A reload caused by a reset line produces no edge pulse.
- R10: Mode 4 and every code not listed in R7 and R8 keep `irq_o[i]` at 0.
- R11: Writes to address 2 or 3 change nothing. Address 3 reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| msg_valid_i | input | 1 | Wire update message strobe |
| msg_index_i | input | 8 | Group index carried by the message |
| msg_data_i | input | 8 | Mask nibble [7:4], value nibble [3:0] |
| rst_lines_i | input | 4 | Candidate reload lines, active-high release |
| irq_o | output | 4 | Per-wire interrupt requests |

## Verification
The assertions assume that the reset lines and the message inputs are synchronous to `clk_i`. They also assume the reset lines are high when `rst_ni` is released, because a line that is low at that point and then rises counts as a genuine reload edge. The bench changes every input only on the falling clock edge. It keeps all four lines high except for deliberate low-then-high pulses. The main sweep covers all 16 mode codes against every pair of old and new wire patterns. It sends only fully masked messages to the matching index, so every wire transition in the sweep comes from one known message.

// File: rtl/vwg_pkg.sv
package vwg_pkg;
  typedef enum logic [3:0] {
    MODE_LVL_LO = 4'd0,
    MODE_LVL_HI = 4'd1,
    MODE_OFF    = 4'd4,
    MODE_RISE   = 4'd13,
    MODE_FALL   = 4'd14,
    MODE_ANY    = 4'd15
  } vw_mode_e;

  localparam logic [1:0] ADDR_CFG   = 2'd0;
  localparam logic [1:0] ADDR_MODE  = 2'd1;
  localparam logic [1:0] ADDR_STATE = 2'd2;
  localparam int unsigned PAT_LSB   = 12;
endpackage

// File: rtl/vwg_regs.sv
module vwg_regs import vwg_pkg::*; #(
  parameter int unsigned NUM    = 4,
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned SRC_W  = 2,
  parameter int unsigned MODE_W = 4,
  parameter int unsigned DATA_W = 32
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic [1:0]            addr_i,
  input  logic [DATA_W-1:0]     wdata_i,
  input  logic [NUM-1:0]        state_i,
  output logic [DATA_W-1:0]     rdata_o,
  output logic [IDX_W-1:0]      index_o,
  output logic [SRC_W-1:0]      src_o,
  output logic [NUM-1:0]        pat_o,
  output logic [NUM*MODE_W-1:0] mode_o
);
  localparam int unsigned LANE_W = DATA_W / NUM;

  logic cfg_we, mode_we, wdata_unused;
  assign cfg_we       = we_i && (addr_i == ADDR_CFG);
  assign mode_we      = we_i && (addr_i == ADDR_MODE);
  assign wdata_unused = ^wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      index_o <= '0;
      src_o   <= '0;
      pat_o   <= '0;
    end else if (cfg_we) begin
      index_o <= wdata_i[IDX_W-1:0];
      src_o   <= wdata_i[IDX_W+SRC_W-1:IDX_W];
      pat_o   <= wdata_i[PAT_LSB+NUM-1:PAT_LSB];
    end
  end

  logic [DATA_W-1:0] mode_rd, state_rd;
  for (genvar i = 0; i < NUM; i++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      mode_o[i*MODE_W +: MODE_W] <= MODE_W'(MODE_OFF);
      else if (mode_we) mode_o[i*MODE_W +: MODE_W] <= wdata_i[i*LANE_W +: MODE_W];
    end
    assign mode_rd[i*LANE_W +: LANE_W]  = LANE_W'(mode_o[i*MODE_W +: MODE_W]);
    assign state_rd[i*LANE_W +: LANE_W] = LANE_W'(state_i[i]);
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_CFG: begin
        rdata_o[IDX_W-1:0]                 = index_o;
        rdata_o[IDX_W+SRC_W-1:IDX_W]       = src_o;
        rdata_o[PAT_LSB+NUM-1:PAT_LSB]     = pat_o;
      end
      ADDR_MODE:  rdata_o = mode_rd;
      ADDR_STATE: rdata_o = state_rd;
      default:    rdata_o = '0;
    endcase
  end

  // R2: a configuration write lands in the fields
  a_r2_cfg_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we |=> (index_o == $past(wdata_i[IDX_W-1:0])) &&
               (pat_o == $past(wdata_i[PAT_LSB+NUM-1:PAT_LSB])));
  // R11: no write to other addresses disturbs the configuration
  a_r11_cfg_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_we && !mode_we |=> $stable(index_o) && $stable(src_o) && $stable(pat_o) && $stable(mode_o));
endmodule

// File: rtl/vwg_state.sv
module vwg_state #(
  parameter int unsigned NUM     = 4,
  parameter int unsigned IDX_W   = 8,
  parameter int unsigned SRC_W   = 2,
  parameter int unsigned MIN_IDX = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               msg_valid_i,
  input  logic [IDX_W-1:0]   msg_index_i,
  input  logic [2*NUM-1:0]   msg_data_i,
  input  logic [(1<<SRC_W)-1:0] rst_lines_i,
  input  logic [IDX_W-1:0]   index_i,
  input  logic [SRC_W-1:0]   src_i,
  input  logic [NUM-1:0]     pat_i,
  output logic [NUM-1:0]     wires_o,
  output logic               reload_o
);
  localparam int unsigned NRST = 1 << SRC_W;

  logic [NRST-1:0] lines_q, line_rise;
  logic [NUM-1:0]  upd_mask, upd_val;
  logic            hit, reload;

  assign upd_mask  = msg_data_i[2*NUM-1:NUM];
  assign upd_val   = msg_data_i[NUM-1:0];
  assign hit       = msg_valid_i && (msg_index_i == index_i) && (index_i >= IDX_W'(MIN_IDX));
  assign line_rise = rst_lines_i & ~lines_q;
  assign reload    = line_rise[src_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lines_q  <= '1;
      wires_o  <= '0;
      reload_o <= 1'b0;
    end else begin
      lines_q  <= rst_lines_i;
      reload_o <= reload;
      if (reload)   wires_o <= pat_i;
      else if (hit) wires_o <= (wires_o & ~upd_mask) | (upd_val & upd_mask);
    end
  end

  // R6: reload loads the pattern, winning over a message
  a_r6_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload |=> wires_o == $past(pat_i));
  // R5: no accepted message and no reload leaves the wires alone
  a_r5_ignore: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit && !reload |=> $stable(wires_o));
  // R4: masked wires take the value, others keep theirs
  a_r4_masked_update: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit && !reload |=> (((wires_o ^ $past(upd_val)) & $past(upd_mask)) == '0) &&
                       (((wires_o ^ $past(wires_o)) & ~$past(upd_mask)) == '0));
endmodule

// File: rtl/vwg_irq.sv
module vwg_irq import vwg_pkg::*; #(
  parameter int unsigned MODE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wire_i,
  input  logic              reload_i,
  input  logic [MODE_W-1:0] mode_i,
  output logic              irq_o
);
  logic prev_q, rise, fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= wire_i;
  end

  // edge seen in the cycle after the wire register changed; reload-driven changes masked
  assign rise = wire_i & ~prev_q & ~reload_i;
  assign fall = ~wire_i & prev_q & ~reload_i;

  always_comb begin
    case (mode_i)
      MODE_LVL_LO: irq_o = ~wire_i;
      MODE_LVL_HI: irq_o = wire_i;
      MODE_RISE:   irq_o = rise;
      MODE_FALL:   irq_o = fall;
      MODE_ANY:    irq_o = rise | fall;
      default:     irq_o = 1'b0;
    endcase
  end

  // R8: a rising request never lasts two cycles
  a_r8_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && mode_i == MODE_RISE) |=> !(irq_o && mode_i == MODE_RISE));
  // R9: reload cycle carries no edge request
  a_r9_no_reload_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload_i && (mode_i == MODE_RISE || mode_i == MODE_FALL || mode_i == MODE_ANY) |-> !irq_o);
endmodule

// File: rtl/vw_host_group.sv
module vw_host_group #(
  parameter int unsigned NUM_WIRES = 4,
  parameter int unsigned IDX_W     = 8,
  parameter int unsigned SRC_W     = 2,
  parameter int unsigned MODE_W    = 4,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned MIN_IDX   = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   reg_we_i,
  input  logic [1:0]             reg_addr_i,
  input  logic [DATA_W-1:0]      reg_wdata_i,
  output logic [DATA_W-1:0]      reg_rdata_o,
  input  logic                   msg_valid_i,
  input  logic [IDX_W-1:0]       msg_index_i,
  input  logic [2*NUM_WIRES-1:0] msg_data_i,
  input  logic [(1<<SRC_W)-1:0]  rst_lines_i,
  output logic [NUM_WIRES-1:0]   irq_o
);
  logic [IDX_W-1:0]            index;
  logic [SRC_W-1:0]            src;
  logic [NUM_WIRES-1:0]        pat, wires;
  logic [NUM_WIRES*MODE_W-1:0] modes;
  logic                        reload_q;

  vwg_regs #(.NUM(NUM_WIRES), .IDX_W(IDX_W), .SRC_W(SRC_W), .MODE_W(MODE_W), .DATA_W(DATA_W)) u_regs (
    .clk_i, .rst_ni, .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .state_i(wires), .rdata_o(reg_rdata_o), .index_o(index), .src_o(src),
    .pat_o(pat), .mode_o(modes));

  vwg_state #(.NUM(NUM_WIRES), .IDX_W(IDX_W), .SRC_W(SRC_W), .MIN_IDX(MIN_IDX)) u_state (
    .clk_i, .rst_ni, .msg_valid_i, .msg_index_i, .msg_data_i, .rst_lines_i,
    .index_i(index), .src_i(src), .pat_i(pat), .wires_o(wires), .reload_o(reload_q));

  for (genvar i = 0; i < NUM_WIRES; i++) begin : g_wire
    vwg_irq #(.MODE_W(MODE_W)) u_irq (
      .clk_i, .rst_ni, .wire_i(wires[i]), .reload_i(reload_q),
      .mode_i(modes[i*MODE_W +: MODE_W]), .irq_o(irq_o[i]));
  end
endmodule

// File: tb/test_vw_host_group.sv
module test_vw_host_group;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        mvalid = 1'b0;
  logic [7:0]  midx = '0;
  logic [7:0]  mdata = '0;
  logic [3:0]  lines = 4'hF;
  logic [3:0]  irq;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  vw_host_group i_vw_host_group (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .msg_valid_i(mvalid), .msg_index_i(midx), .msg_data_i(mdata),
    .rst_lines_i(lines), .irq_o(irq));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic msg(input logic [7:0] idx, input logic [7:0] d);
    @(negedge clk); mvalid = 1'b1; midx = idx; mdata = d;
    @(negedge clk); mvalid = 1'b0;
  endtask

  task automatic pulse_line(input int j);
    @(negedge clk); lines[j] = 1'b0;
    @(negedge clk); lines[j] = 1'b1;
    @(negedge clk);
  endtask

  function automatic logic [31:0] spread(input logic [3:0] w);
    return {7'd0, w[3], 7'd0, w[2], 7'd0, w[1], 7'd0, w[0]};
  endfunction

  function automatic logic [3:0] exp_irq(input int m, input logic [3:0] o, input logic [3:0] n);
    case (m)
      0:  return ~n;
      1:  return n;
      13: return n & ~o;
      14: return ~n & o;
      15: return n ^ o;
      default: return 4'h0;
    endcase
  endfunction

  function automatic string mode_tag(input int m);
    if (m == 0 || m == 1) return "R7";
    if (m >= 13) return "R8";
    return "R10";
  endfunction

  initial begin
    logic [31:0] r;
    logic [3:0] p;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(2'd0, r); chk("R1 cfg", r, 32'h0);
    rd(2'd1, r); chk("R1 mode", r, 32'h04040404);
    rd(2'd2, r); chk("R1 state", r, 32'h0);
    chk("R1 irq", {28'd0, irq}, 32'h0);

    // R2 field layout
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, r); chk("R2 cfg mask", r, 32'h0000_F3FF);
    wr(2'd0, 32'h0000_502A);
    rd(2'd0, r); chk("R2 cfg value", r, 32'h0000_502A);
    // R3 mode layout
    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd1, r); chk("R3 mode mask", r, 32'h0F0F_0F0F);
    wr(2'd1, 32'h04040404);

    // R4 masked update, all masks
    for (int mk = 0; mk < 16; mk++) begin
      msg(8'h2A, 8'hF5);
      msg(8'h2A, {mk[3:0], 4'hA});
      rd(2'd2, r);
      chk("R4 masked update", r, spread((4'h5 & ~mk[3:0]) | (4'hA & mk[3:0])));
    end

    // R5 index matching
    msg(8'h2A, 8'hF0);
    msg(8'h2B, 8'hFF);
    rd(2'd2, r); chk("R5 wrong index", r, 32'h0);
    wr(2'd0, 32'h0000_0001);
    msg(8'h01, 8'hFF);
    rd(2'd2, r); chk("R5 index below min", r, 32'h0);
    wr(2'd0, 32'h0000_0002);
    msg(8'h02, 8'hF6);
    rd(2'd2, r); chk("R5 min index accepted", r, spread(4'h6));

    // R11 read-only addresses
    wr(2'd2, 32'hFFFF_FFFF);
    rd(2'd2, r); chk("R11 state write ignored", r, spread(4'h6));
    wr(2'd3, 32'hFFFF_FFFF);
    rd(2'd3, r); chk("R11 addr3 reads zero", r, 32'h0);
    rd(2'd0, r); chk("R11 cfg untouched", r, 32'h2);

    // R6 reload source selection, R9 no edge on reload
    for (int s = 0; s < 4; s++) begin
      p = 4'h9 ^ s[3:0];
      wr(2'd0, {16'd0, p, 2'd0, s[1:0], 8'h2A});
      wr(2'd1, 32'h0F0F_0F0F);
      msg(8'h2A, {4'hF, ~p});
      @(negedge clk);
      for (int j = 0; j < 4; j++) if (j != s) pulse_line(j);
      rd(2'd2, r); chk("R6 unselected line ignored", r, spread(~p));
      pulse_line(s);
      rd(2'd2, r); chk("R6 selected line reloads", r, spread(p));
      chk("R9 no edge irq on reload", {28'd0, irq}, 32'h0);
      wr(2'd1, 32'h01010101);
      chk("R7 level after reload", {28'd0, irq}, {28'd0, p});
      // reload wins over same-cycle message
      msg(8'h2A, {4'hF, ~p});
      @(negedge clk); lines[s] = 1'b0;
      @(negedge clk); lines[s] = 1'b1; mvalid = 1'b1; midx = 8'h2A; mdata = {4'hF, ~p};
      @(negedge clk); mvalid = 1'b0;
      rd(2'd2, r); chk("R6 reload beats message", r, spread(p));
    end
    wr(2'd0, 32'h0000_002A);

    // R7 R8 R10 sweep: every mode code against every old/new pattern
    for (int m = 0; m < 16; m++) begin
      wr(2'd1, {4'd0, m[3:0], 4'd0, m[3:0], 4'd0, m[3:0], 4'd0, m[3:0]});
      for (int a = 0; a < 16; a++) begin
        for (int b = 0; b < 16; b++) begin
          msg(8'h2A, {4'hF, a[3:0]});
          @(negedge clk);
          msg(8'h2A, {4'hF, b[3:0]});
          chk({mode_tag(m), " irq after update"}, {28'd0, irq}, {28'd0, exp_irq(m, a[3:0], b[3:0])});
          @(negedge clk);
          chk({mode_tag(m), " irq one cycle later"}, {28'd0, irq}, {28'd0, exp_irq(m, b[3:0], b[3:0])});
          if (m == 0 && a == 0) begin
            rd(2'd2, r); chk("R3 state layout", r, spread(b[3:0]));
          end
        end
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule